// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block takes stereo PCM words from a three-wire serial port (bit clock, frame sync, serial data) and hands each finished word, with its channel flag and the C, U and V side bits captured alongside it, to the transmit framing logic. A 3-bit mode input picks one of seven framings. Among them are left-justified, word-sync, I2S-style, LSB-justified at a fixed 16 or 18 bits, and LSB-first. In one mode the block produces the bit clock and frame sync itself from its master clock, which runs at 128 times the sample rate. Every input is assumed to be derived from that master clock. The bit clock is therefore treated as a synchronous level, and data is taken on its rising edges.

Each word is built up in an accumulator while it shifts in. When the frame-sync edge that opens the next word arrives, the finished word moves to an output holding register, so one word is on offer while the next one is being received. Results are always 24 bits wide and MSB-aligned, and any unused low bits are zero. A frame tracker counts master-clock cycles across each 128-cycle frame. When a left word starts too far from the tracker's frame boundary, the tracker realigns itself.

The output is a valid/ready stream. The serial source cannot be stalled, so back-pressure never holds up reception. A word that is not taken stays on offer, unchanged, until the next word finishes. At that point the newer word replaces it.

Top module: `aser_rx`

## Requirements
- R1: The mode input selects the framing: 000 generated clocks, 001 left-justified, 010 word sync, 100 I2S-style, 101 LSB-justified 16-bit, 110 LSB-justified 18-bit, 111 LSB-first. Code 011 behaves exactly like 001.
- R2: In mode 000 the block drives `sclk_o` and `fsync_o` from a 128-cycle counter that starts at zero at reset. `sclk_o` is bit 0 of the counter, so there are 32 bit clocks per sample. `fsync_o` is high while the counter is below 64 and marks the left word. `port_drv` is high only in mode 000. In every other mode the block uses `sclk_i` and `fsync_i`.
- R3: Data, frame sync and side bits are sampled in the cycle where the bit clock reads 1 after reading 0. In mode 010 only a low-to-high change of frame sync begins a word, and the channels alternate starting with left after reset. In all other modes either change of frame sync begins a word.
- R4: In modes 000, 001 and 011 the bit sampled at the opening edge is the MSB (bit 23). In mode 100 the MSB is the next bit after it. Words shorter than 24 bits leave zeros below them, and any bit past the 24th is ignored.
- R5: In mode 101 the last 16 bits before the closing edge appear in `m_data[23:8]`, with `m_data[7:0]` zero. In mode 110 the last 18 bits appear in `m_data[23:6]`, with `m_data[5:0]` zero. Missing leading bits read as zero.
- R6: In mode 111 bits arrive LSB first. The last bit before the closing edge lands in `m_data[23]`, and the earlier bits fill downward. Words shorter than 24 bits leave zeros at the bottom.
- R7: `m_right` is 1 for a right-channel word. In mode 100 it equals the frame-sync level during the word. In modes 000, 001, 011, 101, 110 and 111 it is the inverse of that level.
- R8: `m_cuv` = {C, U, V} as sampled at bit 0 of the word, or at bit 1 in mode 100. A word that ends before that bit reports 000.
- R9: After reset `m_valid` is 0. A word is offered only once it has been opened by an edge and closed by the next one. `m_valid` rises one cycle after the sampling cycle of the closing edge. The first rising bit-clock edge after reset only records the frame-sync level.
- R10: While `m_valid` is high and `m_ready` is low, `m_valid` stays high. A newly finished word replaces the word on offer. An accepted word clears `m_valid` unless a new word finishes in the same cycle.
- R11: `tx_tick` is high whenever the frame counter reads 0, and the counter steps through 128 values. In modes other than 000, a left word that opens while the counter reads 4 to 124 makes `resync` pulse for one cycle, and the counter reads 1 in the cycle after the opening.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 128 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Framing select |
| sclk_i | input | 1 | External bit clock |
| fsync_i | input | 1 | External frame sync |
| sdata_i | input | 1 | Serial audio data |
| c_i | input | 1 | Channel-status side bit |
| u_i | input | 1 | User side bit |
| v_i | input | 1 | Validity side bit |
| sclk_o | output | 1 | Generated bit clock (mode 000) |
| fsync_o | output | 1 | Generated frame sync (mode 000) |
| port_drv | output | 1 | High when the port clocks are to be driven |
| m_valid | output | 1 | Word on offer |
| m_ready | input | 1 | Consumer accepts the word |
| m_data | output | 24 | MSB-aligned sample |
| m_right | output | 1 | Channel flag, 1 for right |
| m_cuv | output | 3 | Side bits {C,U,V} of the word |
| tx_tick | output | 1 | Transmit frame boundary |
| resync | output | 1 | Frame counter realigned |

## Verification
Two functions can fall in the same cycle: the hand-off of a newly finished word, and the consumer accepting the word already on offer. When both happen, `m_valid` must stay high and carry the new word. The bench drives `m_ready` at random on every cycle through runs in every mode. Words end at many different cycles, so this coincidence comes up repeatedly. The expected state is derived from the requirements: a finished word always wins over an acceptance in the same cycle. Frame-sync gaps of three and of five cycles are also inserted, to place left-word openings just inside and just outside the drift window.

// File: rtl/aser_pkg.sv
package aser_pkg;

  typedef enum logic [2:0] {
    FMT_GEN   = 3'd0,
    FMT_LJ    = 3'd1,
    FMT_WSYNC = 3'd2,
    FMT_RSV   = 3'd3,
    FMT_I2S   = 3'd4,
    FMT_RJ16  = 3'd5,
    FMT_RJ18  = 3'd6,
    FMT_LSBF  = 3'd7
  } fmt_e;

  // R1: the reserved code decodes as left-justified
  function automatic fmt_e fmt_norm(input logic [2:0] m);
    return (m == 3'd3) ? FMT_LJ : fmt_e'(m);
  endfunction

  // one-bit data delay after the frame-sync edge
  function automatic logic msb_delay(input fmt_e f);
    return f == FMT_I2S;
  endfunction

  // R7: channel flag from the frame-sync level
  function automatic logic right_of_level(input fmt_e f, input logic lvl);
    return (f == FMT_I2S) ? lvl : ~lvl;
  endfunction

endpackage

// File: rtl/aser_clkgen.sv
module aser_clkgen #(
  parameter int FRAME_CLKS    = 128,
  parameter int BITS_PER_WORD = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic sclk,
  output logic fsync
);
  localparam int CW          = $clog2(FRAME_CLKS);
  localparam int CLK_PER_BIT = FRAME_CLKS / (2 * BITS_PER_WORD);

  logic [CW-1:0] cnt;
  logic [CW-1:0] ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt == CW'(FRAME_CLKS - 1)) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign ph    = cnt % CW'(CLK_PER_BIT);
  assign sclk  = ph >= CW'(CLK_PER_BIT / 2);
  assign fsync = cnt < CW'(FRAME_CLKS / 2);
endmodule

// File: rtl/aser_deser.sv
module aser_deser
  import aser_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int RJ_A   = 16,
  parameter int RJ_B   = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fmt_e              fmt,
  input  logic              sclk,
  input  logic              fsync,
  input  logic              sdata,
  input  logic [2:0]        cuv,
  output logic              done,
  output logic [WORD_W-1:0] d_word,
  output logic              d_right,
  output logic [2:0]        d_cuv,
  output logic              left_start
);
  localparam int IDX_W = $clog2(WORD_W + 2) + 1;
  localparam int PW    = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic              sclk_q, primed, fs_prev, active, tgl, cur_right;
  logic [IDX_W-1:0]  idx, bidx, off;
  logic [WORD_W-1:0] msb_acc, tail, rsh;
  logic [WORD_W-1:0] msb_n, tail_n, rsh_n;
  logic [2:0]        cuv_acc, cuv_n;
  logic              rise, take, edge_raw, wstart, wbit, new_right;
  int                pos;

  assign rise      = sclk & ~sclk_q;
  assign take      = rise & primed;
  assign edge_raw  = (fmt == FMT_WSYNC) ? (fsync & ~fs_prev) : (fsync ^ fs_prev);
  assign wstart    = take & edge_raw;
  assign wbit      = take & (edge_raw | active);
  assign bidx      = wstart ? '0 : idx;
  assign off       = msb_delay(fmt) ? IDX_W'(1) : '0;
  assign new_right = (fmt == FMT_WSYNC) ? tgl : right_of_level(fmt, fsync);

  // MSB-first accumulator (R4)
  always_comb begin
    msb_n = wstart ? '0 : msb_acc;
    pos   = int'(bidx) - int'(off);
    if (pos >= 0 && pos < WORD_W) msb_n[PW'(WORD_W - 1 - pos)] = sdata;
  end

  // trailing-bit accumulators (R5, R6)
  always_comb begin
    tail_n = {(wstart ? {(WORD_W-1){1'b0}} : tail[WORD_W-2:0]), sdata};
    rsh_n  = {sdata, (wstart ? {(WORD_W-1){1'b0}} : rsh[WORD_W-1:1])};
  end

  // side bits (R8)
  always_comb begin
    if (bidx == off)  cuv_n = cuv;
    else if (wstart)  cuv_n = '0;
    else              cuv_n = cuv_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      primed    <= 1'b0;
      fs_prev   <= 1'b0;
      active    <= 1'b0;
      tgl       <= 1'b0;
      cur_right <= 1'b0;
      idx       <= '0;
      msb_acc   <= '0;
      tail      <= '0;
      rsh       <= '0;
      cuv_acc   <= '0;
    end else begin
      sclk_q <= sclk;
      if (rise && !primed) begin
        primed  <= 1'b1;
        fs_prev <= fsync;
      end
      if (take) fs_prev <= fsync;
      if (wstart) begin
        active    <= 1'b1;
        cur_right <= new_right;
        if (fmt == FMT_WSYNC) tgl <= ~tgl;
      end
      if (wbit) begin
        msb_acc <= msb_n;
        tail    <= tail_n;
        rsh     <= rsh_n;
        cuv_acc <= cuv_n;
        idx     <= (bidx == IDX_MAX) ? bidx : bidx + 1'b1;
      end
    end
  end

  always_comb begin
    case (fmt)
      FMT_RJ16: d_word = tail << (WORD_W - RJ_A);
      FMT_RJ18: d_word = tail << (WORD_W - RJ_B);
      FMT_LSBF: d_word = rsh;
      default:  d_word = msb_acc;
    endcase
  end

  assign done       = wstart & active;
  assign d_right    = cur_right;
  assign d_cuv      = cuv_acc;
  assign left_start = wstart & ~new_right;
endmodule

// File: rtl/aser_frmtrk.sv
module aser_frmtrk #(
  parameter int FRAME_CLKS = 128,
  parameter int DRIFT_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev,
  output logic tick,
  output logic resync
);
  localparam int FW = $clog2(FRAME_CLKS);

  logic [FW-1:0] frm;
  logic          drift;

  assign drift = (frm >= FW'(DRIFT_CLKS)) && (frm <= FW'(FRAME_CLKS - DRIFT_CLKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm    <= '0;
      resync <= 1'b0;
    end else begin
      resync <= ev & drift;
      if (ev && drift)                      frm <= FW'(1);
      else if (frm == FW'(FRAME_CLKS - 1)) frm <= '0;
      else                                  frm <= frm + 1'b1;
    end
  end

  assign tick = frm == '0;
endmodule

// File: rtl/aser_outbuf.sv
module aser_outbuf #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [WORD_W-1:0] word,
  input  logic              right,
  input  logic [2:0]        cuv,
  input  logic              ready,
  output logic              valid,
  output logic [WORD_W-1:0] data,
  output logic              right_o,
  output logic [2:0]        cuv_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      data    <= '0;
      right_o <= 1'b0;
      cuv_o   <= '0;
    end else begin
      if (done) begin
        valid   <= 1'b1;
        data    <= word;
        right_o <= right;
        cuv_o   <= cuv;
      end else if (ready) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/aser_rx.sv
module aser_rx
  import aser_pkg::*;
#(
  parameter int WORD_W        = 24,
  parameter int FRAME_CLKS    = 128,
  parameter int BITS_PER_WORD = 32,
  parameter int DRIFT_CLKS    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic              sclk_i,
  input  logic              fsync_i,
  input  logic              sdata_i,
  input  logic              c_i,
  input  logic              u_i,
  input  logic              v_i,
  output logic              sclk_o,
  output logic              fsync_o,
  output logic              port_drv,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [WORD_W-1:0] m_data,
  output logic              m_right,
  output logic [2:0]        m_cuv,
  output logic              tx_tick,
  output logic              resync
);
  fmt_e              fmt;
  logic              gen_sclk, gen_fs, sclk_s, fs_s;
  logic              done, d_right, left_start;
  logic [WORD_W-1:0] d_word;
  logic [2:0]        d_cuv;

  assign fmt    = fmt_norm(mode);
  assign sclk_s = (fmt == FMT_GEN) ? gen_sclk : sclk_i;
  assign fs_s   = (fmt == FMT_GEN) ? gen_fs : fsync_i;

  aser_clkgen #(.FRAME_CLKS(FRAME_CLKS), .BITS_PER_WORD(BITS_PER_WORD)) gen_i (
    .clk(clk), .rst_n(rst_n), .sclk(gen_sclk), .fsync(gen_fs)
  );

  aser_deser #(.WORD_W(WORD_W)) des_i (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .sclk(sclk_s), .fsync(fs_s),
    .sdata(sdata_i), .cuv({c_i, u_i, v_i}), .done(done), .d_word(d_word),
    .d_right(d_right), .d_cuv(d_cuv), .left_start(left_start)
  );

  aser_frmtrk #(.FRAME_CLKS(FRAME_CLKS), .DRIFT_CLKS(DRIFT_CLKS)) trk_i (
    .clk(clk), .rst_n(rst_n), .ev(left_start & (fmt != FMT_GEN)),
    .tick(tx_tick), .resync(resync)
  );

  aser_outbuf #(.WORD_W(WORD_W)) ob_i (
    .clk(clk), .rst_n(rst_n), .done(done), .word(d_word), .right(d_right),
    .cuv(d_cuv), .ready(m_ready), .valid(m_valid), .data(m_data),
    .right_o(m_right), .cuv_o(m_cuv)
  );

  assign sclk_o   = gen_sclk;
  assign fsync_o  = gen_fs;
  assign port_drv = fmt == FMT_GEN;
endmodule

// File: rtl/aser_rx_chk.sv
module aser_rx_chk #(
  parameter int WORD_W = 24,
  parameter int RJ_A   = 16,
  parameter int RJ_B   = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode,
  input logic              port_drv,
  input logic              m_valid,
  input logic              m_ready,
  input logic [WORD_W-1:0] m_data,
  input logic              resync,
  input logic              tx_tick
);
  AST_DRV_ONLY_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'd0) |-> !port_drv); // R2

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> m_valid); // R10

  AST_RJ16_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && mode == 3'd5 && $stable(mode)) |-> (m_data[WORD_W-RJ_A-1:0] == '0)); // R5

  AST_RJ18_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && mode == 3'd6 && $stable(mode)) |-> (m_data[WORD_W-RJ_B-1:0] == '0)); // R5

  AST_RESYNC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !resync); // R11

  AST_NO_RESYNC_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0) |=> !resync); // R11

  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tick |=> !tx_tick); // R11
endmodule

bind aser_rx aser_rx_chk #(.WORD_W(WORD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode), .port_drv(port_drv),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
  .resync(resync), .tx_tick(tx_tick)
);

// File: tb/aser_rx_tb_top.sv
module aser_rx_tb_top;
  localparam int FRAME = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic        sclk_i = 1'b0, fsync_i = 1'b0, sdata_i = 1'b0;
  logic        c_i = 1'b0, u_i = 1'b0, v_i = 1'b0;
  logic        m_ready = 1'b0;
  logic        sclk_o, fsync_o, port_drv, m_valid, m_right, tx_tick, resync;
  logic [23:0] m_data;
  logic [2:0]  m_cuv;

  always #4 clk = ~clk;

  aser_rx dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sclk_i(sclk_i), .fsync_i(fsync_i),
    .sdata_i(sdata_i), .c_i(c_i), .u_i(u_i), .v_i(v_i), .sclk_o(sclk_o),
    .fsync_o(fsync_o), .port_drv(port_drv), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_right(m_right), .m_cuv(m_cuv), .tx_tick(tx_tick),
    .resync(resync)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_cyc = 0, m_frm = 0, m_cuv_acc = 0;
  bit m_psclk = 0, m_primed = 0, m_pfs = 0, m_active = 0, m_tgl = 0, m_rgt = 0;
  int m_bits[$];
  bit e_valid = 0, e_right = 0, e_resync = 0;
  int e_data = 0, e_cuv = 0;

  function automatic int decode(int f);
    int r = 0;
    int n = m_bits.size();
    case (f)
      5, 6: begin
        int nb = (f == 5) ? 16 : 18;
        for (int j = 0; j < nb && j < n; j++) r |= m_bits[n-1-j] << (24 - nb + j);
      end
      7: for (int j = 0; j < 24 && j < n; j++) r |= m_bits[n-1-j] << (23 - j);
      default: begin
        int o = (f == 4) ? 1 : 0;
        for (int k = o; k < n && (k - o) < 24; k++) r |= m_bits[k] << (23 - (k - o));
      end
    endcase
    return r;
  endfunction

  always @(posedge clk) begin
    int f, nd, nc;
    bit sc, fs, rise, ed, done, ev, nr;
    if (!rst_n) begin
      m_cyc = 0; m_frm = 0; m_cuv_acc = 0; m_psclk = 0; m_primed = 0; m_pfs = 0;
      m_active = 0; m_tgl = 0; m_rgt = 0; m_bits.delete();
      e_valid = 0; e_right = 0; e_resync = 0; e_data = 0; e_cuv = 0;
    end else begin
      f  = (mode == 3'd3) ? 1 : int'(mode);
      sc = (f == 0) ? ((m_cyc % 2) == 1) : sclk_i;
      fs = (f == 0) ? (m_cyc < FRAME / 2) : fsync_i;
      done = 0; ev = 0; nd = 0; nc = 0; nr = 0;
      rise = sc && !m_psclk;
      m_psclk = sc;
      if (rise) begin
        if (!m_primed) begin
          m_primed = 1; m_pfs = fs;
        end else begin
          ed = (f == 2) ? (fs && !m_pfs) : (fs != m_pfs);
          m_pfs = fs;
          if (ed) begin
            if (m_active) begin done = 1; nd = decode(f); nr = m_rgt; nc = m_cuv_acc; end
            m_active = 1; m_bits.delete(); m_cuv_acc = 0;
            m_rgt = (f == 2) ? m_tgl : ((f == 4) ? fs : !fs);
            if (f == 2) m_tgl = !m_tgl;
            ev = !m_rgt && (f != 0);
          end
          if (m_active) begin
            if (m_bits.size() == ((f == 4) ? 1 : 0)) m_cuv_acc = int'({c_i, u_i, v_i});
            m_bits.push_back(int'(sdata_i));
          end
        end
      end
      if (done) begin e_valid = 1; e_data = nd; e_right = nr; e_cuv = nc; end
      else if (e_valid && m_ready) e_valid = 0;
      if (ev && m_frm >= 4 && m_frm <= FRAME - 4) begin m_frm = 1; e_resync = 1; end
      else begin m_frm = (m_frm + 1) % FRAME; e_resync = 0; end
      m_cyc = (m_cyc + 1) % FRAME;
    end
  end

  function automatic string data_tag(logic [2:0] m);
    case (m)
      3'd3: return "R1";
      3'd2: return "R3";
      3'd5, 3'd6: return "R5";
      3'd7: return "R6";
      default: return "R4";
    endcase
  endfunction

  // compare away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2", "port_drv", int'(port_drv), int'(mode == 3'd0));
      if (mode == 3'd0) begin
        chk("R2", "sclk_o", int'(sclk_o), int'((m_cyc % 2) == 1));
        chk("R2", "fsync_o", int'(fsync_o), int'(m_cyc < FRAME / 2));
      end
      chk("R9_R10", "m_valid", int'(m_valid), int'(e_valid));
      if (e_valid && m_valid) begin
        chk(data_tag(mode), "m_data", int'(m_data), e_data);
        chk("R7", "m_right", int'(m_right), int'(e_right));
        chk("R8", "m_cuv", int'(m_cuv), e_cuv);
      end
      chk("R11", "tx_tick", int'(tx_tick), int'(m_frm == 0));
      chk("R11", "resync", int'(resync), int'(e_resync));
    end
  end

  // ---------------- stimulus ----------------
  task automatic bit_out(bit lvl, bit d);
    @(negedge clk);
    sclk_i = 1'b0; fsync_i = lvl; sdata_i = d; {c_i, u_i, v_i} = 3'($urandom);
    @(negedge clk);
    sclk_i = 1'b1;
  endtask

  task automatic word_out(bit lvl, int n, bit pulse);
    for (int k = 0; k < n; k++) bit_out(pulse ? (k == 0) : lvl, 1'($urandom));
  endtask

  task automatic frame_out(int f, int n);
    bit lvl = (f == 4) ? 1'b0 : 1'b1;
    word_out(lvl, n, f == 2);
    word_out(!lvl, n, f == 2);
  endtask

  task automatic idle(int k);
    repeat (k) begin @(negedge clk); sclk_i = 1'b0; end
  endtask

  task automatic start(int m);
    @(negedge clk);
    rst_n = 1'b0; mode = 3'(m); sclk_i = 1'b0;
    fsync_i = (m == 4) ? 1'b1 : 1'b0;
    repeat (2) @(negedge clk);
    chk("R9", "m_valid in reset", int'(m_valid), 0);
    chk("R11", "resync in reset", int'(resync), 0);
    rst_n = 1'b1;
    bit_out(fsync_i, 1'b0);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      m_ready = ($urandom % 10) < 6;
    end
  end

  initial begin
    start(0);
    repeat (700) begin
      @(negedge clk);
      sdata_i = 1'($urandom); {c_i, u_i, v_i} = 3'($urandom);
    end
    start(1);
    repeat (4) frame_out(1, 32);
    repeat (2) frame_out(1, 20);
    repeat (2) frame_out(1, 28);
    repeat (2) frame_out(1, 32);
    idle(3); repeat (2) frame_out(1, 32);
    idle(5); repeat (2) frame_out(1, 32);
    start(2);
    repeat (4) frame_out(2, 32);
    repeat (2) frame_out(2, 24);
    frame_out(2, 32);
    start(3);
    repeat (3) frame_out(1, 32);
    start(4);
    repeat (4) frame_out(4, 32);
    repeat (2) frame_out(4, 17);
    frame_out(4, 1);
    frame_out(4, 32);
    start(5);
    repeat (3) frame_out(5, 32);
    repeat (2) frame_out(5, 12);
    frame_out(5, 32);
    start(6);
    repeat (3) frame_out(6, 32);
    repeat (2) frame_out(6, 20);
    frame_out(6, 32);
    start(7);
    repeat (3) frame_out(7, 32);
    repeat (2) frame_out(7, 16);
    frame_out(7, 32);
    idle(20);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule